// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Unit

This block holds a small set of hardware lock flags that two independent requesters, called the left and right ports, use to share resources. Each port has its own set of active-low semaphore and chip enables, a read/write line, an active-low output enable, two active-low byte selects and a three-bit flag address. A port asks for a flag by writing 0 on data bit 0 and frees it by writing 1. A read returns that port's view of the flag, copied onto all sixteen read-data bits: 0 means the port holds the flag, 1 means it does not.

A flag belongs to at most one port at a time. A request that arrives while the other port holds the flag is kept and granted by the hardware on the edge where the holder frees the flag. When both ports request the same free flag on the same edge, the left port gets it. Driving the semaphore enable and the chip enable low together is illegal: the access is dropped and the port's error output rises.

Both ports are sampled on one clock edge, with no handshake between them. Reset is synchronous and active high.

Top module: `sem_unit`

## Requirements
- R1: After reset all eight flags, selected by the 3-bit address, are free, and a read of any flag from either port returns 16'hFFFF.
- R2: An access happens only when the semaphore enable is low and the chip enable is high. With the semaphore enable high, a write changes nothing and the read data is 16'h0000.
- R3: A read (read/write = 1, output enable low) puts the port's view bit on all 16 read-data bits. With the output enable high the read data is 16'h0000.
- R4: A write (read/write = 0) takes effect only if at least one byte select is low. It uses only data bit 0 (0 = request, 1 = free), and both byte selects high make it a no-op.
- R5: Semaphore enable low together with chip enable low changes no flag state, and the port's error output is 1 in the cycle after that input, 0 otherwise.
- R6: A request for a free flag grants it on that edge. From the next cycle the owner reads 0 and the other port reads 1. A request from the other port does not take the flag away.
- R7: A request blocked by the other port's ownership stays pending and is granted on the edge where the owner writes 1. From the next cycle the new owner reads 0.
- R8: When both ports request the same free flag on one edge, the left port gets it and the right request stays pending.
- R9: A write of 1 by the owner frees the flag. A write of 1 by the non-owner cancels that port's pending request and leaves ownership unchanged.
- R10: The flags are independent: an access to one flag does not change what any other flag reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| l_sem_n | input | 1 | Left semaphore enable, active low |
| l_ce_n | input | 1 | Left chip enable, active low (must be high for an access) |
| l_rw | input | 1 | Left read (1) / write (0) |
| l_oe_n | input | 1 | Left output enable, active low |
| l_ub_n | input | 1 | Left upper byte select, active low |
| l_lb_n | input | 1 | Left lower byte select, active low |
| l_addr | input | 3 | Left flag address |
| l_wdata | input | 16 | Left write data, only bit 0 used |
| l_rdata | output | 16 | Left read data |
| l_err | output | 1 | Left illegal-combination flag |
| r_sem_n | input | 1 | Right semaphore enable, active low |
| r_ce_n | input | 1 | Right chip enable, active low (must be high for an access) |
| r_rw | input | 1 | Right read (1) / write (0) |
| r_oe_n | input | 1 | Right output enable, active low |
| r_ub_n | input | 1 | Right upper byte select, active low |
| r_lb_n | input | 1 | Right lower byte select, active low |
| r_addr | input | 3 | Right flag address |
| r_wdata | input | 16 | Right write data, only bit 0 used |
| r_rdata | output | 16 | Right read data |
| r_err | output | 1 | Right illegal-combination flag |

## Verification
Every flag in turn goes through the same sequences: left takes it and right is blocked; the flag is handed over on release; both ports request it on the same edge; the non-owner cancels its request. After each step the bench reads every flag from both ports, which separates the owner's view from the other port's view and catches any effect on a neighbouring flag. Writes whose upper data bits are the opposite of bit 0, and writes with one byte select or neither, show whether only bit 0 and the byte-select gate decide the outcome. Illegal enable combinations, deselected writes and reads with the output enable high show whether state stays unchanged and the outputs stay quiet.

// File: rtl/sem_pkg.sv
package sem_pkg;

    localparam int unsigned FLAGS_DEF  = 8;
    localparam int unsigned DATA_W_DEF = 16;

    typedef enum logic [1:0] {
        HOLD_NONE  = 2'd0,
        HOLD_LEFT  = 2'd1,
        HOLD_RIGHT = 2'd2
    } holder_e;

    typedef struct packed {
        logic rd;   // valid semaphore read
        logic wr;   // valid semaphore write
        logic bad;  // illegal enable combination
        logic val;  // written bit
    } access_t;

    function automatic access_t decode_access(
        input logic sem_n, input logic ce_n, input logic rw, input logic oe_n,
        input logic ub_n, input logic lb_n, input logic d0);
        access_t a;
        a.bad = ~sem_n & ~ce_n;
        a.rd  = ~sem_n & ce_n & rw & ~oe_n;
        a.wr  = ~sem_n & ce_n & ~rw & ~(ub_n & lb_n);
        a.val = d0;
        return a;
    endfunction

    function automatic logic view_bit(input holder_e h, input logic is_left);
        logic mine;
        mine = is_left ? (h == HOLD_LEFT) : (h == HOLD_RIGHT);
        return ~mine;
    endfunction

endpackage

// File: rtl/sem_port_decode.sv
module sem_port_decode
    import sem_pkg::*;
#(
    parameter int unsigned DATA_W = DATA_W_DEF
) (
    input  logic              sem_n,
    input  logic              ce_n,
    input  logic              rw,
    input  logic              oe_n,
    input  logic              ub_n,
    input  logic              lb_n,
    input  logic [DATA_W-1:0] wdata,
    output access_t           acc
);
    logic unused_upper;
    assign unused_upper = ^wdata[DATA_W-1:1];

    assign acc = decode_access(sem_n, ce_n, rw, oe_n, ub_n, lb_n, wdata[0]);
endmodule

// File: rtl/sem_flag_cell.sv
module sem_flag_cell
    import sem_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    l_take,
    input  logic    l_give,
    input  logic    r_take,
    input  logic    r_give,
    output holder_e holder,
    output logic    l_wait,
    output logic    r_wait
);
    holder_e nxt;
    logic    l_want, r_want, l_wait_nxt, r_wait_nxt;

    always_comb begin
        l_want = (l_wait | l_take) & ~l_give;
        r_want = (r_wait | r_take) & ~r_give;
        nxt    = holder;
        case (holder)
            HOLD_NONE: begin
                if (l_want)      nxt = HOLD_LEFT;
                else if (r_want) nxt = HOLD_RIGHT;
            end
            HOLD_LEFT:  if (l_give) nxt = r_want ? HOLD_RIGHT : HOLD_NONE;
            HOLD_RIGHT: if (r_give) nxt = l_want ? HOLD_LEFT  : HOLD_NONE;
            default:    nxt = HOLD_NONE;
        endcase
        l_wait_nxt = l_want & (nxt != HOLD_LEFT);
        r_wait_nxt = r_want & (nxt != HOLD_RIGHT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            holder <= HOLD_NONE;
            l_wait <= 1'b0;
            r_wait <= 1'b0;
        end else begin
            holder <= nxt;
            l_wait <= l_wait_nxt;
            r_wait <= r_wait_nxt;
        end
    end
endmodule

// File: rtl/sem_readback.sv
module sem_readback
    import sem_pkg::*;
#(
    parameter int unsigned NUM_FLAGS = FLAGS_DEF,
    parameter int unsigned DATA_W    = DATA_W_DEF,
    parameter bit          IS_LEFT   = 1'b1,
    localparam int unsigned SEL_W    = $clog2(NUM_FLAGS)
) (
    input  logic [NUM_FLAGS-1:0][1:0] hold_vec,
    input  access_t                   acc,
    input  logic [SEL_W-1:0]          sel,
    output logic [DATA_W-1:0]         rdata
);
    logic bit_v;
    assign bit_v = view_bit(holder_e'(hold_vec[sel]), IS_LEFT);
    assign rdata = acc.rd ? {DATA_W{bit_v}} : '0;
endmodule

// File: rtl/sem_unit.sv
module sem_unit
    import sem_pkg::*;
#(
    parameter int unsigned NUM_FLAGS = FLAGS_DEF,
    parameter int unsigned DATA_W    = DATA_W_DEF,
    localparam int unsigned SEL_W    = $clog2(NUM_FLAGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              l_sem_n,
    input  logic              l_ce_n,
    input  logic              l_rw,
    input  logic              l_oe_n,
    input  logic              l_ub_n,
    input  logic              l_lb_n,
    input  logic [SEL_W-1:0]  l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    output logic              l_err,
    input  logic              r_sem_n,
    input  logic              r_ce_n,
    input  logic              r_rw,
    input  logic              r_oe_n,
    input  logic              r_ub_n,
    input  logic              r_lb_n,
    input  logic [SEL_W-1:0]  r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata,
    output logic              r_err
);
    access_t                   l_acc, r_acc;
    logic [NUM_FLAGS-1:0][1:0] hold_vec;
    logic [NUM_FLAGS-1:0]      l_wait, r_wait;

    sem_port_decode #(.DATA_W(DATA_W)) u_ldec (
        .sem_n(l_sem_n), .ce_n(l_ce_n), .rw(l_rw), .oe_n(l_oe_n),
        .ub_n(l_ub_n), .lb_n(l_lb_n), .wdata(l_wdata), .acc(l_acc));

    sem_port_decode #(.DATA_W(DATA_W)) u_rdec (
        .sem_n(r_sem_n), .ce_n(r_ce_n), .rw(r_rw), .oe_n(r_oe_n),
        .ub_n(r_ub_n), .lb_n(r_lb_n), .wdata(r_wdata), .acc(r_acc));

    for (genvar k = 0; k < NUM_FLAGS; k++) begin : g_flag
        holder_e hc;
        logic    l_hit, r_hit;
        assign l_hit = l_acc.wr & (l_addr == SEL_W'(k));
        assign r_hit = r_acc.wr & (r_addr == SEL_W'(k));

        sem_flag_cell u_cell (
            .clk(clk), .rst(rst),
            .l_take(l_hit & ~l_acc.val), .l_give(l_hit & l_acc.val),
            .r_take(r_hit & ~r_acc.val), .r_give(r_hit & r_acc.val),
            .holder(hc), .l_wait(l_wait[k]), .r_wait(r_wait[k]));

        assign hold_vec[k] = hc;
    end

    sem_readback #(.NUM_FLAGS(NUM_FLAGS), .DATA_W(DATA_W), .IS_LEFT(1'b1)) u_lrb (
        .hold_vec(hold_vec), .acc(l_acc), .sel(l_addr), .rdata(l_rdata));

    sem_readback #(.NUM_FLAGS(NUM_FLAGS), .DATA_W(DATA_W), .IS_LEFT(1'b0)) u_rrb (
        .hold_vec(hold_vec), .acc(r_acc), .sel(r_addr), .rdata(r_rdata));

    always_ff @(posedge clk) begin
        if (rst) begin
            l_err <= 1'b0;
            r_err <= 1'b0;
        end else begin
            l_err <= l_acc.bad;
            r_err <= r_acc.bad;
        end
    end
endmodule

// File: rtl/sem_unit_chk.sv
module sem_unit_chk #(
    parameter int unsigned NUM_FLAGS = 8,
    parameter int unsigned DATA_W    = 16,
    localparam int unsigned SEL_W    = $clog2(NUM_FLAGS)
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      l_sem_n, l_ce_n, l_rw, l_oe_n, l_ub_n, l_lb_n, l_d0,
    input logic [SEL_W-1:0]          l_addr,
    input logic [DATA_W-1:0]         l_rdata,
    input logic                      l_err,
    input logic                      r_sem_n, r_ce_n, r_rw, r_oe_n, r_ub_n, r_lb_n, r_d0,
    input logic [SEL_W-1:0]          r_addr,
    input logic                      r_err,
    input logic [NUM_FLAGS-1:0][1:0] hold_vec,
    input logic [NUM_FLAGS-1:0]      l_wait,
    input logic [NUM_FLAGS-1:0]      r_wait
);
    logic l_rd, l_wr, l_bad, r_wr, r_bad;
    assign l_rd  = !l_sem_n && l_ce_n && l_rw && !l_oe_n;
    assign l_wr  = !l_sem_n && l_ce_n && !l_rw && !(l_ub_n && l_lb_n);
    assign r_wr  = !r_sem_n && r_ce_n && !r_rw && !(r_ub_n && r_lb_n);
    assign l_bad = !l_sem_n && !l_ce_n;
    assign r_bad = !r_sem_n && !r_ce_n;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !l_rd |-> l_rdata == '0);  // R2
    AST_OWNER_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (l_rd && hold_vec[l_addr] == 2'd1) |-> l_rdata == '0);  // R6
    AST_OTHER_READS_ONE: assert property (@(posedge clk) disable iff (rst)
        (l_rd && hold_vec[l_addr] != 2'd1) |-> l_rdata == '1);  // R3
    AST_BAD_RAISES_ERR: assert property (@(posedge clk) disable iff (rst)
        l_bad |=> l_err);  // R5
    AST_RIGHT_BAD_ERR: assert property (@(posedge clk) disable iff (rst)
        r_bad |=> r_err);  // R5
    AST_BAD_KEEPS_STATE: assert property (@(posedge clk) disable iff (rst)
        (l_bad && r_sem_n) |=> ($stable(hold_vec) && $stable(l_wait) && $stable(r_wait)));  // R5

    for (genvar k = 0; k < NUM_FLAGS; k++) begin : g_chk
        logic l_req, r_req, l_rel, r_rel;
        assign l_req = l_wr && (l_addr == SEL_W'(k)) && !l_d0;
        assign l_rel = l_wr && (l_addr == SEL_W'(k)) && l_d0;
        assign r_req = r_wr && (r_addr == SEL_W'(k)) && !r_d0;
        assign r_rel = r_wr && (r_addr == SEL_W'(k)) && r_d0;

        AST_LEFT_WINS: assert property (@(posedge clk) disable iff (rst)
            (l_req && r_req && hold_vec[k] == 2'd0) |=> (hold_vec[k] == 2'd1 && r_wait[k]));  // R8
        AST_HOLD_STAYS: assert property (@(posedge clk) disable iff (rst)
            (hold_vec[k] == 2'd1 && !l_rel) |=> hold_vec[k] == 2'd1);  // R6
        AST_WAIT_ONLY_WHEN_HELD: assert property (@(posedge clk) disable iff (rst)
            l_wait[k] |-> hold_vec[k] == 2'd2);  // R7
        AST_HANDOVER: assert property (@(posedge clk) disable iff (rst)
            (hold_vec[k] == 2'd1 && l_rel && r_wait[k] && !r_rel) |=> hold_vec[k] == 2'd2);  // R7
        AST_CANCEL_KEEPS_OWNER: assert property (@(posedge clk) disable iff (rst)
            (hold_vec[k] == 2'd1 && r_rel && !l_rel) |=> (hold_vec[k] == 2'd1 && !r_wait[k]));  // R9
    end
endmodule

bind sem_unit sem_unit_chk #(.NUM_FLAGS(NUM_FLAGS), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst),
    .l_sem_n(l_sem_n), .l_ce_n(l_ce_n), .l_rw(l_rw), .l_oe_n(l_oe_n),
    .l_ub_n(l_ub_n), .l_lb_n(l_lb_n), .l_d0(l_wdata[0]),
    .l_addr(l_addr), .l_rdata(l_rdata), .l_err(l_err),
    .r_sem_n(r_sem_n), .r_ce_n(r_ce_n), .r_rw(r_rw), .r_oe_n(r_oe_n),
    .r_ub_n(r_ub_n), .r_lb_n(r_lb_n), .r_d0(r_wdata[0]),
    .r_addr(r_addr), .r_err(r_err),
    .hold_vec(hold_vec), .l_wait(l_wait), .r_wait(r_wait));

// File: tb/sim_sem_unit.sv
`timescale 1ns/1ps
module sim_sem_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lsem, lce, lrw, loe, lub, llb;
    logic [2:0]  laddr;
    logic [15:0] lwd, lrd;
    logic        lerr;
    logic        rsem, rce, rrw, roe, rub, rlb;
    logic [2:0]  raddr;
    logic [15:0] rwd, rrd;
    logic        rerr;

    int total = 0;
    int bad   = 0;
    int own [8];   // 0 free, 1 left, 2 right
    bit done  = 1'b0;

    always #5 clk = ~clk;

    sem_unit u0 (
        .clk(clk), .rst(rst),
        .l_sem_n(lsem), .l_ce_n(lce), .l_rw(lrw), .l_oe_n(loe), .l_ub_n(lub), .l_lb_n(llb),
        .l_addr(laddr), .l_wdata(lwd), .l_rdata(lrd), .l_err(lerr),
        .r_sem_n(rsem), .r_ce_n(rce), .r_rw(rrw), .r_oe_n(roe), .r_ub_n(rub), .r_lb_n(rlb),
        .r_addr(raddr), .r_wdata(rwd), .r_rdata(rrd), .r_err(rerr));

    task automatic idle();
        lsem = 1; lce = 1; lrw = 1; loe = 1; lub = 1; llb = 1; laddr = 0; lwd = 0;
        rsem = 1; rce = 1; rrw = 1; roe = 1; rub = 1; rlb = 1; raddr = 0; rwd = 0;
    endtask

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    task automatic set_wr(input bit side, input int a, input logic [15:0] wd,
                          input bit sem, input bit ce, input bit ub, input bit lb);
        if (!side) begin
            lsem = sem; lce = ce; lrw = 0; lub = ub; llb = lb; laddr = 3'(a); lwd = wd;
        end else begin
            rsem = sem; rce = ce; rrw = 0; rub = ub; rlb = lb; raddr = 3'(a); rwd = wd;
        end
    endtask

    // ordinary write; upper data bits are the opposite of bit 0
    task automatic wr(input bit side, input int a, input bit v);
        set_wr(side, a, v ? 16'h0001 : 16'hFFFE, 0, 1, 0, 0);
        tick();
    endtask

    task automatic rd(input bit side, input int a, output logic [15:0] got);
        if (!side) begin lsem = 0; lce = 1; lrw = 1; loe = 0; laddr = 3'(a); end
        else       begin rsem = 0; rce = 1; rrw = 1; roe = 0; raddr = 3'(a); end
        #2;
        got = side ? rrd : lrd;
        idle();
        #1;
    endtask

    task automatic check_all(input string tag);
        logic [15:0] got;
        for (int j = 0; j < 8; j++) begin
            for (int s = 0; s < 2; s++) begin
                rd(s[0], j, got);
                chk(tag, got, (own[j] == s + 1) ? 16'h0000 : 16'hFFFF);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: got hung expected done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] got;
        idle();
        for (int j = 0; j < 8; j++) own[j] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        chk("R5 reset err", {14'h0, lerr, rerr}, 16'h0);
        check_all("R1");

        for (int k = 0; k < 8; k++) begin
            // take, block, hand over, free
            wr(0, k, 0); own[k] = 1; check_all("R6 left takes");
            wr(1, k, 0);             check_all("R6 right blocked");
            wr(0, k, 1); own[k] = 2; check_all("R7 handover");
            wr(1, k, 1); own[k] = 0; check_all("R9 owner frees");
            // same-edge requests
            set_wr(0, k, 16'hFFFE, 0, 1, 0, 0);
            set_wr(1, k, 16'hFFFE, 0, 1, 0, 0);
            tick(); own[k] = 1; check_all("R8 left wins");
            wr(0, k, 1); own[k] = 2; check_all("R8 right pending granted");
            wr(1, k, 1); own[k] = 0;
            // non-owner cancel
            wr(0, k, 0); own[k] = 1;
            wr(1, k, 0);
            wr(1, k, 1); check_all("R9 cancel keeps owner");
            wr(0, k, 1); own[k] = 0; check_all("R9 cancelled not granted");
        end

        // R10: two flags held by different ports at once
        wr(0, 3, 0); own[3] = 1;
        wr(1, 5, 0); own[5] = 2;
        check_all("R10");
        wr(0, 3, 1); own[3] = 0;
        wr(1, 5, 1); own[5] = 0;

        // R5: illegal enables, write and read forms
        set_wr(0, 2, 16'h0000, 0, 0, 0, 0);
        tick();
        chk("R5 left err", {15'h0, lerr}, 16'h1);
        check_all("R5 no change");
        tick();
        chk("R5 err clears", {15'h0, lerr}, 16'h0);
        rsem = 0; rce = 0; rrw = 1; roe = 0; raddr = 3'd4;
        #2; chk("R2 illegal read quiet", rrd, 16'h0000);
        tick();
        chk("R5 right err", {15'h0, rerr}, 16'h1);

        // R2: semaphore enable high
        set_wr(0, 1, 16'h0000, 1, 1, 0, 0);
        tick();
        check_all("R2 deselected write");
        lsem = 1; lce = 0; lrw = 1; loe = 0; laddr = 3'd1;
        #2; chk("R2 deselected read", lrd, 16'h0000);
        idle(); #1;

        // R4: byte-select gate and bit 0 only
        set_wr(1, 6, 16'hFFFE, 0, 1, 0, 1);
        tick(); own[6] = 2; check_all("R4 upper select request");
        set_wr(1, 6, 16'h0001, 0, 1, 1, 0);
        tick(); own[6] = 0; check_all("R4 lower select release");
        set_wr(0, 6, 16'h0000, 0, 1, 1, 1);
        tick(); check_all("R4 no byte select");
        set_wr(0, 7, 16'hFFFF, 0, 1, 1, 0);
        tick(); check_all("R4 bit0 one on free flag");

        // R3: output enable high while owning
        wr(0, 0, 0); own[0] = 1;
        lsem = 0; lce = 1; lrw = 1; loe = 1; laddr = 3'd0;
        #2; chk("R3 oe high", lrd, 16'h0000);
        idle(); #1;
        rd(0, 0, got); chk("R3 owner replicated", got, 16'h0000);
        rd(1, 0, got); chk("R3 other replicated", got, 16'hFFFF);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule